// File: doc/BRIEF.md
# Programmable Memory Control Waveform Sequencer

This block produces the control waveforms for memories that need multi-step timing, such as dynamic RAM. It does not hard-code those waveforms in a state machine. Instead it plays them back from a 64-entry by 32-bit pattern store that the host fills through a plain write port. Each stored word carries the following controls: five general-purpose strobes, a row/column address-multiplex select, a wait request, a bus transfer acknowledge and an end-of-sequence marker.

Four kinds of event start playback, each at its own fixed entry in the store. The events are a single access (read or write), a burst access (read or write), a refresh request from an external timer, and an exception. From that entry the sequencer advances one word per clock. It stops on a word that carries the end marker, or on the top entry of the store. Between sequences the outputs show a host-programmed idle word. A refresh that arrives while a sequence runs is held and served when that sequence ends, ahead of any held access. An exception cuts the running sequence short at once.

Top module: `patseq_top`

## Requirements
- R1: After a synchronous active-low reset, every pattern entry, the idle word and all outputs are zero, and `busy` is low.
- R2: A sequence starts at entry 0 for a single read, 8 for a single write, 16 for a burst read, 32 for a burst write, 48 for a refresh and 60 for an exception. The access kind is encoded as `acc_burst` (1 = burst) and `acc_write` (1 = write). Only `acc_req` is sampled on the edge where the request is taken; its kind is sampled with it.
- R3: A sequence begins on the edge where its request is taken. After that edge the outputs show the start entry, and then the next entry after each further edge. The bits of the pattern word map as follows: bits [4:0] drive `gpo`, bit 5 drives `amux_sel`, bit 6 drives `wait_flag`, bit 7 drives `xfer_ack` and bit 8 drives `seq_last`. Bits [31:9] have no effect.
- R4: A sequence ends after the word whose bit 8 is set is shown. It also ends after entry 63 is shown, even when bit 8 is clear there. The next pending request then starts on the following edge. If nothing is pending, the outputs show the idle word.
- R5: While the shown word has bit 6 set and `wait_release` is low, the sequence stays on that word.
- R6: A refresh request is remembered until it is served. When a sequence ends or the block is idle, a pending refresh is served before a pending access. If a second access arrives while one access is already pending, the second one is dropped.
- R7: An exception request takes effect on the next edge in every state. It restarts playback at entry 60, abandoning any sequence that was running or holding.
- R8: A host pattern write is refused, leaving the store unchanged, when `busy` is high or when a sequence starts on the same edge.
- R9: Writing the idle word (`host_idle_sel` = 1) is always accepted. Every output takes the new idle value from the second edge after the write, for as long as no sequence runs.
- R10: `busy` is high exactly while a sequence word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_idle_sel | input | 1 | 1: the write targets the idle word; 0: the write targets a pattern entry |
| host_addr | input | ADDR_W | Pattern entry index for the write |
| host_wdata | input | WORD_W | Write data |
| acc_req | input | 1 | Memory access request |
| acc_burst | input | 1 | Access is a burst |
| acc_write | input | 1 | Access is a write |
| refresh_req | input | 1 | Refresh request pulse from the timer |
| exc_req | input | 1 | Exception request pulse |
| wait_release | input | 1 | Releases a word that requests a wait |
| busy | output | 1 | A sequence is running |
| gpo | output | 5 | General-purpose strobes from the current word |
| amux_sel | output | 1 | Row/column address select |
| wait_flag | output | 1 | Wait bit of the current word |
| xfer_ack | output | 1 | Transfer acknowledge to the bus |
| seq_last | output | 1 | End marker of the current word |

## Verification
Most internal faults in this block show at the ports within a cycle. A wrong entry pointer, a wrong start index or a misread word makes the output word differ from the programmed pattern on the very next edge. A wrong hold or end decision shows up as a repeated word, a skipped word, or an early or late return to the idle word. A lost or reordered pending request is visible later, at the end of the running sequence: there the wrong sequence starts, or none does. A write that was wrongly accepted while busy stays hidden until that entry is played again. The bench therefore replays the affected sequence after each refused write.

// File: rtl/patseq_pkg.sv
`timescale 1ns/1ps
// Package: shared word layout of the pattern sequencer.
// Assumes the control fields sit in the low bits of each pattern word.
package patseq_pkg;
    localparam int GPO_W  = 5;   // general-purpose strobe count
    localparam int AMUX_B = 5;   // address multiplex select bit
    localparam int WAIT_B = 6;   // wait request bit
    localparam int ACK_B  = 7;   // transfer acknowledge bit
    localparam int LAST_B = 8;   // end-of-sequence bit
    localparam int CTL_W  = 9;   // control bits actually used per word
endpackage

// File: rtl/patseq_ram.sv
`timescale 1ns/1ps
// Module: pattern store. Register-based, one write port with a refusal
// input and one combinational read port. Assumes the read address is
// stable before the clock edge on which its data is captured.
module patseq_ram #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_block,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: clear on reset, accept host writes unless refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && !wr_block) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Purpose: asynchronous read of the addressed entry.
    always_comb rd_data = mem[rd_addr];

    // R8: a refused write leaves the addressed entry untouched
    a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_block) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
    // R8: an accepted write lands in the addressed entry
    a_r8_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_block) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/patseq_arb.sv
`timescale 1ns/1ps
// Module: event arbiter. Holds pending refresh and access requests and
// picks the start entry when the stepper offers a slot. An exception
// wins at once, regardless of the slot.
module patseq_arb #(
    parameter int ADDR_W  = 6,
    parameter int SRD_IDX = 0,
    parameter int SWR_IDX = 8,
    parameter int BRD_IDX = 16,
    parameter int BWR_IDX = 32,
    parameter int REF_IDX = 48,
    parameter int EXC_IDX = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_burst,
    input  logic              acc_write,
    input  logic              ref_req,
    input  logic              exc_req,
    input  logic              slot_open,
    output logic              start_vld,
    output logic [ADDR_W-1:0] start_idx
);
    logic ref_pend, acc_pend, pend_burst, pend_write;
    logic ref_any, acc_any, kind_burst, kind_write;
    logic take_ref, take_acc;
    logic [ADDR_W-1:0] acc_idx;

    // Purpose: merge live requests with the held ones.
    always_comb begin
        ref_any    = ref_pend | ref_req;
        acc_any    = acc_pend | acc_req;
        kind_burst = acc_pend ? pend_burst : acc_burst;
        kind_write = acc_pend ? pend_write : acc_write;
    end

    // Purpose: map the access kind to its start entry.
    always_comb begin
        unique case ({kind_burst, kind_write})
            2'b00:   acc_idx = ADDR_W'(SRD_IDX);
            2'b01:   acc_idx = ADDR_W'(SWR_IDX);
            2'b10:   acc_idx = ADDR_W'(BRD_IDX);
            default: acc_idx = ADDR_W'(BWR_IDX);
        endcase
    end

    // Purpose: priority choice, exception over refresh over access.
    always_comb begin
        take_ref  = slot_open && !exc_req && ref_any;
        take_acc  = slot_open && !exc_req && !ref_any && acc_any;
        start_vld = exc_req || take_ref || take_acc;
        if (exc_req)       start_idx = ADDR_W'(EXC_IDX);
        else if (take_ref) start_idx = ADDR_W'(REF_IDX);
        else               start_idx = acc_idx;
    end

    // Purpose: hold requests that could not be served yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pend   <= 1'b0;
            acc_pend   <= 1'b0;
            pend_burst <= 1'b0;
            pend_write <= 1'b0;
        end else begin
            ref_pend <= ref_any && !take_ref;
            if (take_acc) begin
                acc_pend <= 1'b0;
            end else if (!acc_pend && acc_req) begin
                acc_pend   <= 1'b1;
                pend_burst <= acc_burst;
                pend_write <= acc_write;
            end
        end
    end

    // R6: a held refresh is not lost while no slot is offered
    a_r6_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !slot_open) |=> ref_pend);
    // R6: a held access survives while a refresh is being preferred
    a_r6_acc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pend && (ref_any || exc_req || !slot_open)) |=> acc_pend);
endmodule

// File: rtl/patseq_step.sv
`timescale 1ns/1ps
// Module: stepper. Tracks the running flag and entry pointer, prefetches
// the next word, and registers the control word driven to the pins.
// Assumes the pattern store reads combinationally at rd_addr.
module patseq_step
    import patseq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_idx,
    input  logic              wait_release,
    input  logic [CTL_W-1:0]  idle_word,
    input  logic [CTL_W-1:0]  fetch_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              slot_open,
    output logic              running,
    output logic [ADDR_W-1:0] cur_idx,
    output logic [CTL_W-1:0]  word_q
);
    logic [ADDR_W-1:0] ptr, ptr_inc;
    logic hold, end_now, at_top;

    // Purpose: decide hold, end and next fetch address.
    always_comb begin
        ptr_inc   = ptr + 1'b1;
        at_top    = (ptr == {ADDR_W{1'b1}});
        hold      = running && word_q[WAIT_B] && !wait_release;
        end_now   = running && !hold && (word_q[LAST_B] || at_top);
        slot_open = !running || end_now;
        rd_addr   = start_vld ? start_idx : ptr_inc;
        cur_idx   = ptr;
    end

    // Purpose: advance the sequence and register the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ptr     <= '0;
            word_q  <= '0;
        end else if (start_vld) begin
            running <= 1'b1;
            ptr     <= start_idx;
            word_q  <= fetch_word;
        end else if (end_now) begin
            running <= 1'b0;
            word_q  <= idle_word;
        end else if (running && !hold) begin
            ptr    <= ptr_inc;
            word_q <= fetch_word;
        end else if (!running) begin
            word_q <= idle_word;
        end
    end

    // R2: a launch places the pointer on the chosen start entry
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |=> (running && ptr == $past(start_idx)));
    // R3: an ordinary step moves to the following entry
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !hold && !end_now && !start_vld)
        |=> (running && ptr == ADDR_W'($past(ptr) + 1'b1)));
    // R5: a wait holds pointer and word
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start_vld) |=> (running && $stable(ptr) && $stable(word_q)));
    // R4: an end without a new start returns to the idle word
    a_r4_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (end_now && !start_vld) |=> (!running && word_q == $past(idle_word)));
endmodule

// File: rtl/patseq_top.sv
`timescale 1ns/1ps
// Module: programmable memory control waveform sequencer, top level.
// Plays host-loaded pattern words one per clock from event-specific
// start entries. Assumes refresh and exception requests are one-cycle
// pulses and that the refresh timer lives outside.
module patseq_top
    import patseq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int WORD_W  = 32,
    parameter int SRD_IDX = 0,
    parameter int SWR_IDX = 8,
    parameter int BRD_IDX = 16,
    parameter int BWR_IDX = 32,
    parameter int REF_IDX = 48,
    parameter int EXC_IDX = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_idle_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              acc_req,
    input  logic              acc_burst,
    input  logic              acc_write,
    input  logic              refresh_req,
    input  logic              exc_req,
    input  logic              wait_release,
    output logic              busy,
    output logic [GPO_W-1:0]  gpo,
    output logic              amux_sel,
    output logic              wait_flag,
    output logic              xfer_ack,
    output logic              seq_last
);
    logic [WORD_W-1:0] idle_q, rd_data;
    logic [ADDR_W-1:0] rd_addr, start_idx, cur_idx;
    logic [CTL_W-1:0]  word_q;
    logic start_vld, slot_open, running, pat_we, pat_block;
    logic unused_rsvd;

    // Purpose: route host writes and fold away the reserved bits.
    always_comb begin
        pat_we      = host_we && !host_idle_sel;
        pat_block   = running || start_vld;
        unused_rsvd = ^{rd_data[WORD_W-1:CTL_W], idle_q[WORD_W-1:CTL_W]};
    end

    // Purpose: idle word register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                        idle_q <= '0;
        else if (host_we && host_idle_sel) idle_q <= host_wdata;
    end

    patseq_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(pat_we), .wr_block(pat_block),
        .wr_addr(host_addr), .wr_data(host_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    patseq_arb #(
        .ADDR_W(ADDR_W), .SRD_IDX(SRD_IDX), .SWR_IDX(SWR_IDX),
        .BRD_IDX(BRD_IDX), .BWR_IDX(BWR_IDX), .REF_IDX(REF_IDX),
        .EXC_IDX(EXC_IDX)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_burst(acc_burst),
        .acc_write(acc_write), .ref_req(refresh_req), .exc_req(exc_req),
        .slot_open(slot_open), .start_vld(start_vld), .start_idx(start_idx)
    );

    patseq_step #(.ADDR_W(ADDR_W)) u_step (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_idx(start_idx),
        .wait_release(wait_release), .idle_word(idle_q[CTL_W-1:0]),
        .fetch_word(rd_data[CTL_W-1:0]), .rd_addr(rd_addr),
        .slot_open(slot_open), .running(running), .cur_idx(cur_idx),
        .word_q(word_q)
    );

    // Purpose: drive the pins from the registered word.
    always_comb begin
        busy      = running;
        gpo       = word_q[GPO_W-1:0];
        amux_sel  = word_q[AMUX_B];
        wait_flag = word_q[WAIT_B];
        xfer_ack  = word_q[ACK_B];
        seq_last  = word_q[LAST_B];
    end

    // R7: an exception lands on its entry on the next edge
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (busy && cur_idx == ADDR_W'(EXC_IDX)));
    // R10: busy never drops on an edge where a start was taken
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |=> busy);
endmodule

// File: tb/patseq_top_tb.sv
`timescale 1ns/1ps
module patseq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 0, host_idle_sel = 0;
    logic [5:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic acc_req = 0, acc_burst = 0, acc_write = 0;
    logic refresh_req = 0, exc_req = 0, wait_release = 1;
    logic busy, amux_sel, wait_flag, xfer_ack, seq_last;
    logic [4:0] gpo;

    always #2.5 clk = ~clk;

    patseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idle_sel(host_idle_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .acc_req(acc_req),
        .acc_burst(acc_burst), .acc_write(acc_write), .refresh_req(refresh_req),
        .exc_req(exc_req), .wait_release(wait_release), .busy(busy), .gpo(gpo),
        .amux_sel(amux_sel), .wait_flag(wait_flag), .xfer_ack(xfer_ack),
        .seq_last(seq_last)
    );

    typedef struct { logic [9:0] v; string tag; } item_t;
    item_t q[$];
    logic [31:0] model [64];
    logic [31:0] idle_m = '0;
    int n_total = 0, n_pass = 0;
    bit done = 0;

    function automatic logic [9:0] obs();
        return {busy, seq_last, xfer_ack, wait_flag, amux_sel, gpo};
    endfunction

    function automatic void check(logic [9:0] got, logic [9:0] exp, string tag);
        n_total++;
        if (got === exp) n_pass++;
        else $display("FAIL %s: got %h expected %h", tag, got, exp);
    endfunction

    // Pattern: gpo = 7*i, amux = bit 1 of i, ack and last on the closing
    // entry of each region, reserved bits filled with noise.
    function automatic logic [31:0] pat(int i);
        logic [31:0] w;
        bit lst;
        lst = (i == 3) || (i == 10) || (i == 23) || (i == 35) || (i == 50) || (i == 62);
        w = (32'(i) * 32'd13) << 9;
        w[4:0] = 5'(i * 7);
        w[5] = 1'(i >> 1);
        w[7] = lst;
        w[8] = lst;
        return w;
    endfunction

    // Scoreboard producers
    task automatic push_w(logic [31:0] w, string tag);
        q.push_back('{v: {1'b1, w[8:0]}, tag: tag});
    endtask
    task automatic push_run(int s, string tag);
        for (int i = s; i < 64; i++) begin
            push_w(model[i], tag);
            if (model[i][8] || i == 63) break;
        end
    endtask
    task automatic push_idle(string tag);
        q.push_back('{v: {1'b0, idle_m[8:0]}, tag: tag});
    endtask
    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(bit idle, int a, logic [31:0] d);
        @(negedge clk);
        host_we = 1; host_idle_sel = idle; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_we = 0; host_idle_sel = 0;
    endtask

    task automatic access(bit b, bit w, int s, string tag);
        @(negedge clk);
        acc_req = 1; acc_burst = b; acc_write = w;
        push_run(s, tag); push_idle(tag);
        @(negedge clk);
        acc_req = 0;
        drain();
    endtask

    // Monitor: compare one expected item per edge while the queue holds any
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(obs(), it.v, it.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(obs(), 10'h000, "R1 reset outputs and busy");

        // R1: cleared store, exception runs 60..63 of zero words (R4 top end)
        @(negedge clk);
        exc_req = 1; push_run(60, "R1 cleared store"); push_idle("R1 idle after");
        @(negedge clk);
        exc_req = 0;
        drain();

        for (int i = 0; i < 64; i++) begin
            model[i] = pat(i);
            host_write(0, i, model[i]);
        end

        // R2 / R3 / R4 / R10: each access kind at its own start entry
        access(0, 0, 0,  "R2 single read");
        access(0, 1, 8,  "R2 single write");
        access(1, 0, 16, "R3 burst read");
        access(1, 1, 32, "R10 burst write");
        @(negedge clk);
        refresh_req = 1; push_run(48, "R2 refresh"); push_idle("R4 idle");
        @(negedge clk);
        refresh_req = 0;
        drain();

        // R9: new idle word appears at the outputs
        idle_m = 32'hA5A5_A0B6;
        host_write(1, 0, idle_m);
        push_idle("R9 idle word");
        push_idle("R9 idle word held");
        drain();

        // R6: refresh and access together, refresh goes first, back to back
        @(negedge clk);
        acc_req = 1; acc_burst = 0; acc_write = 0; refresh_req = 1;
        push_run(48, "R6 refresh first"); push_run(0, "R6 access after");
        push_idle("R6 idle");
        @(negedge clk);
        acc_req = 0; refresh_req = 0;
        drain();

        // R6: refresh and access arriving mid-sequence wait for its end
        @(negedge clk);
        acc_req = 1; acc_burst = 0; acc_write = 0;
        push_run(0, "R6 running read"); push_run(48, "R6 held refresh");
        push_run(8, "R6 held write"); push_idle("R6 idle 2");
        @(negedge clk);
        acc_write = 1; refresh_req = 1;
        @(negedge clk);
        acc_req = 0; acc_write = 0; refresh_req = 0;
        drain();

        // R8: pattern write during a run is refused
        @(negedge clk);
        acc_req = 1; push_run(0, "R8 run"); push_idle("R8 idle");
        @(negedge clk);
        acc_req = 0; host_we = 1; host_addr = 6'd2; host_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        host_we = 0;
        drain();
        access(0, 0, 0, "R8 entry unchanged");

        // R5: wait bit on entry 1 holds while release is low
        model[1][6] = 1'b1;
        host_write(0, 1, model[1]);
        @(negedge clk);
        wait_release = 0; acc_req = 1; acc_burst = 0; acc_write = 0;
        push_w(model[0], "R5 first");
        push_w(model[1], "R5 hold a"); push_w(model[1], "R5 hold b");
        push_w(model[1], "R5 hold c");
        push_w(model[2], "R5 released"); push_w(model[3], "R5 last");
        push_idle("R5 idle");
        @(negedge clk);
        acc_req = 0;
        repeat (3) @(negedge clk);
        wait_release = 1;
        drain();

        // R4: entry 63 ends a sequence without an end marker
        model[62][8:7] = 2'b00;
        host_write(0, 62, model[62]);
        @(negedge clk);
        exc_req = 1; push_run(60, "R4 top entry end"); push_idle("R4 idle top");
        @(negedge clk);
        exc_req = 0;
        drain();

        // R7: exception aborts a burst after two words
        @(negedge clk);
        acc_req = 1; acc_burst = 1; acc_write = 0;
        push_w(model[16], "R7 burst w0"); push_w(model[17], "R7 burst w1");
        push_run(60, "R7 abort to exception"); push_idle("R7 idle");
        @(negedge clk);
        acc_req = 0; acc_burst = 0;
        @(negedge clk);
        exc_req = 1;
        @(negedge clk);
        exc_req = 0;
        drain();

        // R3: reserved upper bits have no effect on the outputs
        model[8] = model[8] ^ 32'hFFFF_FE00;
        host_write(0, 8, model[8]);
        access(0, 1, 8, "R3 reserved bits");

        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule